// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit offset into a 20-bit physical address the way a 16-bit processor with segment registers does: it shifts a 16-bit segment value left by four bits and adds the offset. The result lies in a 1 MB space. Each segment value therefore opens a window of 64 KB that starts at sixteen times that value. Four segment registers are held inside the block: code, stack, data and extra.

Every request carries an access kind. The block uses the kind to pick a segment register without being told which one. Instruction fetches use code, accesses based on the stack or frame pointer use stack, other data accesses use data, and string destinations use extra. The caller can replace that choice with an explicit register override. A far pointer can supply its own segment value, and that value bypasses the registers entirely.

The segment registers are loaded through a write port. The physical address is returned one clock after the request, together with a valid flag.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is low and in the first cycle after it, `out_valid` is 0 and `out_addr` is 0. After reset the code register holds 0xFFFF and the other three hold 0, so a fetch at offset 0 yields 0xFFFF0.
- R2: A request with `req_valid`=1 in cycle n gives `out_valid`=1 in cycle n+1, with `out_addr` = segment*16 + offset. A cycle without a request gives `out_valid`=0 one cycle later.
- R3: With no override and no far pointer, `req_kind` selects the register: 0 fetch selects code, 1 stack selects stack, 2 data selects data, 3 string destination selects extra.
- R4: When `ovr_valid`=1 and `far_valid`=0, `ovr_sel` selects the register instead (0 code, 1 stack, 2 data, 3 extra), whatever `req_kind` is.
- R5: When `far_valid`=1, `far_seg` is the segment. Both `ovr_valid` and the stored registers are ignored.
- R6: Carry out of bit 19 is discarded. For example, segment 0xFFFF with offset 0xFFFF gives 0x0FFEF.
- R7: `seg_wr_en`=1 loads `seg_wr_data` into the register named by `seg_wr_sel` (same encoding as R4). A request in the same cycle still sees the old value. Requests from the next cycle onward see the new value.
- R8: `out_addr` keeps its last value in every cycle that follows a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Address request this cycle |
| req_kind | input | 2 | Access kind used for implicit segment choice |
| req_offset | input | 16 | Offset within the segment |
| ovr_valid | input | 1 | Explicit segment override present |
| ovr_sel | input | 2 | Register named by the override |
| far_valid | input | 1 | Request carries a far pointer |
| far_seg | input | 16 | Segment part of the far pointer |
| seg_wr_en | input | 1 | Load a segment register |
| seg_wr_sel | input | 2 | Register to load |
| seg_wr_data | input | 16 | Value to load |
| out_valid | output | 1 | Registered address is valid |
| out_addr | output | 20 | Registered physical address |

## Verification
Two functions can fall in the same cycle: a segment register load and a request that reads the same register. Under R7, that request must still form its address from the old value. The bench sets up this collision on purpose for each register and also through an override. It also produces it at random in a long mixed sequence. Its behavioural model applies each write only after it has computed that cycle's address, and it compares the output on every clock with what the model predicts.

// File: rtl/seg_addr_pkg.sv
// Package: shared types and helpers for the segmented address generator.
// Assumes four segment registers with the index encoding listed below.
package seg_addr_pkg;

    localparam int NUM_SEGS = 4;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_STACK = 2'd1,
        SEG_DATA  = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_t;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'd0,
        ACC_STACK  = 2'd1,
        ACC_DATA   = 2'd2,
        ACC_STRDST = 2'd3
    } acc_kind_t;

    // Map an access kind to the register it uses when nothing overrides it.
    function automatic seg_id_t implicit_seg(acc_kind_t kind);
        case (kind)
            ACC_FETCH:  return SEG_CODE;
            ACC_STACK:  return SEG_STACK;
            ACC_DATA:   return SEG_DATA;
            default:    return SEG_EXTRA;
        endcase
    endfunction

endpackage

// File: rtl/seg_regfile.sv
// Module: seg_regfile
// Holds the segment registers. One register can be written per cycle.
// Assumes the register read in a cycle is the value stored before that cycle's write.
// Reset gives the code register CODE_RST and every other register zero.
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int SEG_W    = 16,
    parameter int NSEG     = NUM_SEGS,
    parameter logic [SEG_W-1:0] CODE_RST = '1,
    localparam int SEL_W   = $clog2(NSEG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [SEG_W-1:0]           wr_data,
    output logic [NSEG-1:0][SEG_W-1:0] seg_q
);

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        localparam logic [SEG_W-1:0] RST_VAL =
            (g == int'(SEG_CODE)) ? CODE_RST : '0;

        // Load this register when the write port names it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q[g] <= RST_VAL;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                seg_q[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/seg_select.sv
// Module: seg_select
// Chooses the segment value for a request.
// Priority, highest first: far pointer segment, then explicit override, then
// the implicit register given by the access kind. Purely combinational.
module seg_select
    import seg_addr_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int NSEG   = NUM_SEGS,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic [1:0]                 kind,
    input  logic                       ovr_valid,
    input  logic [SEL_W-1:0]           ovr_sel,
    input  logic                       far_valid,
    input  logic [SEG_W-1:0]           far_seg,
    input  logic [NSEG-1:0][SEG_W-1:0] seg_q,
    output logic [SEG_W-1:0]           seg_out
);

    logic [SEL_W-1:0] idx;

    // Pick the register index: the override wins over the implicit choice.
    always_comb begin
        if (ovr_valid) begin
            idx = ovr_sel;
        end else begin
            idx = SEL_W'(implicit_seg(acc_kind_t'(kind)));
        end
    end

    // A far pointer bypasses the register file.
    always_comb begin
        seg_out = far_valid ? far_seg : seg_q[idx];
    end

endmodule

// File: rtl/seg_addr_adder.sv
// Module: seg_addr_adder
// Shifts the segment left by SHIFT bits and adds the zero-extended offset.
// Assumes ADDR_W = SEG_W + SHIFT; carry out of the top bit is dropped.
module seg_addr_adder #(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int SHIFT  = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] base;

    // Form the segment base and the wrapped sum.
    always_comb begin
        base = {seg, {SHIFT{1'b0}}};
        addr = base + ADDR_W'(ofs);
    end

endmodule

// File: rtl/seg_addr_gen.sv
// Module: seg_addr_gen (top)
// Builds a physical address from a segment and an offset and returns it
// registered, one cycle after the request.
// Assumes the caller keeps far_valid and ovr_valid low when they do not apply.
// A segment load in the same cycle as a request affects only later requests.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int SHIFT  = 4,
    parameter logic [SEG_W-1:0] CODE_RST = 16'hFFFF,
    localparam int NSEG   = NUM_SEGS,
    localparam int SEL_W  = $clog2(NSEG),
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic              ovr_valid,
    input  logic [SEL_W-1:0]  ovr_sel,
    input  logic              far_valid,
    input  logic [SEG_W-1:0]  far_seg,
    input  logic              seg_wr_en,
    input  logic [SEL_W-1:0]  seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr
);

    logic [NSEG-1:0][SEG_W-1:0] seg_q;
    logic [SEG_W-1:0]           seg_pick;
    logic [ADDR_W-1:0]          addr_next;

    seg_regfile #(
        .SEG_W    (SEG_W),
        .NSEG     (NSEG),
        .CODE_RST (CODE_RST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .seg_q   (seg_q)
    );

    seg_select #(
        .SEG_W (SEG_W),
        .NSEG  (NSEG)
    ) u_sel (
        .kind      (req_kind),
        .ovr_valid (ovr_valid),
        .ovr_sel   (ovr_sel),
        .far_valid (far_valid),
        .far_seg   (far_seg),
        .seg_q     (seg_q),
        .seg_out   (seg_pick)
    );

    seg_addr_adder #(
        .SEG_W (SEG_W),
        .OFS_W (OFS_W),
        .SHIFT (SHIFT)
    ) u_add (
        .seg  (seg_pick),
        .ofs  (req_offset),
        .addr (addr_next)
    );

    // Register the valid flag for every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= req_valid;
        end
    end

    // Capture a new address only when a request is present; otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr <= '0;
        end else if (req_valid) begin
            out_addr <= addr_next;
        end
    end

endmodule

// File: rtl/seg_addr_chk.sv
// Module: seg_addr_chk
// Checks the top-level port behaviour over time.
// Attached to every seg_addr_gen instance by the bind below.
module seg_addr_chk #(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int SHIFT  = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [OFS_W-1:0]  req_offset,
    input logic              far_valid,
    input logic [SEG_W-1:0]  far_seg,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R2

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(out_addr)); // R8

    AST_FAR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && far_valid) |=>
        out_addr == ADDR_W'({$past(far_seg), {SHIFT{1'b0}}} + ADDR_W'($past(req_offset)))); // R5

    AST_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && far_valid && (&far_seg) && (req_offset >= OFS_W'(16))) |=>
        out_addr == ADDR_W'($past(req_offset) - OFS_W'(16))); // R6

endmodule

bind seg_addr_gen seg_addr_chk #(
    .SEG_W (SEG_W),
    .OFS_W (OFS_W),
    .SHIFT (SHIFT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_offset (req_offset),
    .far_valid  (far_valid),
    .far_seg    (far_seg),
    .out_valid  (out_valid),
    .out_addr   (out_addr)
);

// File: tb/test_seg_addr_gen.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the design on every clock.
module test_seg_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_offset = '0;
    logic        ovr_valid = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic        far_valid = 1'b0;
    logic [15:0] far_seg = '0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        out_valid;
    logic [19:0] out_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    // Model state: index 0 code, 1 stack, 2 data, 3 extra.
    int m_seg[4];
    int m_last;

    always #2 clk = ~clk;

    seg_addr_gen i_seg_addr_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_offset  (req_offset),
        .ovr_valid   (ovr_valid),
        .ovr_sel     (ovr_sel),
        .far_valid   (far_valid),
        .far_seg     (far_seg),
        .seg_wr_en   (seg_wr_en),
        .seg_wr_sel  (seg_wr_sel),
        .seg_wr_data (seg_wr_data),
        .out_valid   (out_valid),
        .out_addr    (out_addr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    // One clock with the inputs set now (at a falling edge), then compare.
    task automatic tick(input string tag);
        int s;
        int exp_addr;
        bit exp_v;
        exp_v = req_valid;
        if (far_valid)      s = int'(far_seg);
        else if (ovr_valid) s = m_seg[ovr_sel];
        else                s = m_seg[req_kind];
        exp_addr = ((s * 16) + int'(req_offset)) % 32'h100000;
        if (req_valid) m_last = exp_addr;
        if (seg_wr_en) m_seg[seg_wr_sel] = int'(seg_wr_data);
        @(posedge clk);
        @(negedge clk);
        check(out_valid == exp_v, {tag, " R2 valid"}, int'(out_valid), int'(exp_v));
        check(int'(out_addr) == m_last, exp_v ? tag : {tag, " R8 hold"},
              int'(out_addr), m_last);
    endtask

    task automatic idle_inputs();
        req_valid = 0; ovr_valid = 0; far_valid = 0; seg_wr_en = 0;
    endtask

    task automatic req(input int kind, input int ofs);
        idle_inputs();
        req_valid = 1; req_kind = 2'(kind); req_offset = 16'(ofs);
    endtask

    task automatic wr(input int sel, input int val);
        seg_wr_en = 1; seg_wr_sel = 2'(sel); seg_wr_data = 16'(val);
    endtask

    initial begin
        m_seg[0] = 32'hFFFF; m_seg[1] = 0; m_seg[2] = 0; m_seg[3] = 0;
        m_last = 0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
        check(out_addr == 20'h0, "R1 reset addr", int'(out_addr), 0);
        rst_n = 1'b1;
        idle_inputs();
        tick("R1 first idle");

        // R1: fetch right after reset uses the code reset value.
        req(0, 0);
        tick("R1 fetch after reset");
        check(out_addr == 20'hFFFF0, "R1 reset vector", int'(out_addr), 32'hFFFF0);

        // R7: load every register, then use each by kind (R3).
        idle_inputs(); wr(0, 16'h0100); tick("R7 load code");
        idle_inputs(); wr(1, 16'h2000); tick("R7 load stack");
        idle_inputs(); wr(2, 16'h1234); tick("R7 load data");
        idle_inputs(); wr(3, 16'hABCD); tick("R7 load extra");
        req(0, 16'h0010); tick("R3 fetch code");
        req(1, 16'hFFFE); tick("R3 stack kind");
        req(2, 16'h5678); tick("R3 data kind");
        check(out_addr == 20'h179B8, "R3 data sum", int'(out_addr), 32'h179B8);
        req(3, 16'h0001); tick("R3 string dest extra");

        // R7: write and read the same register in one cycle.
        for (int r = 0; r < 4; r++) begin
            req(r, 16'h0040); wr(r, 16'h0F00 + r); tick("R7 same-cycle old value");
            req(r, 16'h0040); tick("R7 next-cycle new value");
        end

        // R4: override beats kind.
        req(0, 16'h0002); ovr_valid = 1; ovr_sel = 2'd3; tick("R4 override to extra");
        req(3, 16'h0003); ovr_valid = 1; ovr_sel = 2'd1; tick("R4 override to stack");
        req(1, 16'h0004); ovr_valid = 1; ovr_sel = 2'd2; wr(2, 16'h7777);
        tick("R4 R7 override with same-cycle load");

        // R5: far pointer beats override and registers.
        req(2, 16'h0123); ovr_valid = 1; ovr_sel = 2'd0; far_valid = 1; far_seg = 16'hB800;
        tick("R5 far pointer");
        check(out_addr == 20'hB8123, "R5 far sum", int'(out_addr), 32'hB8123);

        // R6: wrap past 1 MB.
        req(0, 16'hFFFF); far_valid = 1; far_seg = 16'hFFFF; tick("R6 far wrap");
        check(out_addr == 20'h0FFEF, "R6 wrap value", int'(out_addr), 32'h0FFEF);
        idle_inputs(); wr(0, 16'hFFFF); tick("R6 load code max");
        req(0, 16'h0010); tick("R6 code wrap to zero");

        // R8: idle cycles hold the address.
        idle_inputs(); tick("R8 idle 1");
        idle_inputs(); req_offset = 16'h5555; tick("R8 idle 2");

        // R2: mixed random traffic with collisions.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r0;
            logic [31:0] r1;
            r0 = $urandom; r1 = $urandom;
            req_valid   = r0[0] | r0[1];
            req_kind    = r0[3:2];
            ovr_valid   = (r0[6:4] == 3'd0);
            ovr_sel     = r0[8:7];
            far_valid   = (r0[11:9] == 3'd0);
            far_seg     = r1[31:16];
            seg_wr_en   = (r0[13:12] == 2'd0);
            seg_wr_sel  = r0[15:14];
            seg_wr_data = r0[31:16];
            req_offset  = r1[15:0];
            tick("R2 random");
        end

        summary();
        $finish;
    end

endmodule